// File: doc/BRIEF.md
# Load/Store-Multiple Register Sequencer

This block walks a single load-multiple or store-multiple operation through a run of consecutive memory locations. A register-list field names the registers to move: a count selects a leading portion of a fixed table of callee-saved registers, and a separate flag adds the return-address register. The block issues one memory request per register. It reads the register file for stores and writes it for loads. It advances the address by the access size after every accepted beat.

A pipeline issues a command with a one-cycle `start` pulse. The command carries the base address, the 5-bit list field, a load/store select and a word/doubleword select. The sequencer then owns the memory port until it raises `done` for one cycle. The register table follows the order 16, 17, 18, 19, 20, 21, 22, 23 and then 30. Register 31 always comes last when it is requested. In word mode, loaded values are sign-extended to the full register width.

Top module: `lsm_sequencer`

## Requirements
- R1: While reset is held, and after it is released, the block is idle with `busy`, `memReq`, `rfWriteEn` and `done` all low. A reset asserted in the middle of an operation returns it to this idle state.
- R2: With `regList[3:0]` = n and 1 <= n <= 9, the first n beats move the registers 16, 17, ... in table order. The table ends 23 then 30. Each register moves exactly once, one per accepted beat.
- R3: A count of 0 or of 10 to 15 moves no table register.
- R4: `regList[4]` = 1 adds one final beat for register 31. Its address is the one after the last table beat, or the base address when no table beat took place.
- R5: Beat k uses address base + k*4 in word mode (`isDouble` = 0, `memSize` = 0) and base + k*8 in doubleword mode (`isDouble` = 1, `memSize` = 1). `memWrite` is 1 for a store (`isLoad` = 0) and 0 for a load.
- R6: On an accepted load beat, `rfWriteEn` is high in that same cycle with the current register index. In doubleword mode `rfWriteData` equals `memRdata`. In word mode it is `memRdata[31:0]` sign-extended from bit 31.
- R7: During a store beat, `rfReadIdx` names the current register. `memWdata` carries the register value in doubleword mode, and its low 32 bits zero-extended in word mode.
- R8: While `memReq` is high and `memReady` is low, the next cycle keeps `memReq` high with the same address and register. No register is skipped or repeated.
- R9: `done` is high for exactly one cycle, in the cycle after the last accepted beat. `busy` is high from the cycle after `start` through the `done` cycle, and low afterwards.
- R10: A list with no table register and `regList[4]` = 0 makes no memory request and raises `done` in the cycle after `start`.
- R11: A `start` pulse while `busy` is high is ignored, and the operation in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| baseAddr | input | ADDR_W | First memory address of the run |
| regList | input | 5 | Bits 3:0 table count, bit 4 adds register 31 |
| isLoad | input | 1 | 1 = load from memory, 0 = store to memory |
| isDouble | input | 1 | 1 = doubleword beats, 0 = word beats |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | Request is a write |
| memSize | output | 1 | 1 = doubleword, 0 = word |
| memAddr | output | ADDR_W | Request address |
| memWdata | output | XLEN | Store data |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRdata | input | XLEN | Load data, valid with `memReady` |
| rfReadIdx | output | 5 | Register file read index |
| rfReadData | input | XLEN | Register file read data, combinational |
| rfWriteEn | output | 1 | Register file write enable |
| rfWriteIdx | output | 5 | Register file write index |
| rfWriteData | output | XLEN | Register file write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: a 32-bit address and 64-bit registers. The 64-bit width makes the word-mode sign extension and zero extension visible in the upper 32 bits, so both can be checked there. The full 32-bit address space lets runs start at high and top-of-space addresses. The bench also gives the memory-read pattern both polarities of bit 31. Ready patterns with stalls, the full nine-entry table plus register 31, and out-of-range counts are all reachable with these values.

// File: rtl/lsm_pkg.sv
`timescale 1ns/1ps
package lsm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } lsmStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new command
    logic active;   // a beat is being offered to memory
    logic step;     // the offered beat is accepted
  } lsmStrobeT;

endpackage

// File: rtl/lsm_ctrl.sv
`timescale 1ns/1ps
module lsm_ctrl
  import lsm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      cmdEmpty,
  input  logic      lastSlot,
  input  logic      memReady,
  output lsmStrobeT strobes,
  output logic      memReq,
  output logic      busy,
  output logic      done
);

  lsmStateT stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.capture = 1'b1;
          stateD = cmdEmpty ? ST_DONE : ST_XFER;
        end
      end
      ST_XFER: begin
        strobes.active = 1'b1;
        if (memReady) begin
          strobes.step = 1'b1;
          if (lastSlot) stateD = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memReq = (stateQ == ST_XFER);
  assign busy   = (stateQ != ST_IDLE);
  assign done   = (stateQ == ST_DONE);

endmodule

// File: rtl/lsm_datapath.sv
`timescale 1ns/1ps
module lsm_datapath
  import lsm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int XLEN       = 64,
  parameter int BASE_FIRST = 16,
  parameter int BASE_RUN   = 8,
  parameter int EXTRA_REG  = 30,
  parameter int LINK_REG   = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsmStrobeT         strobes,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [4:0]        regList,
  input  logic              isLoad,
  input  logic              isDouble,
  output logic              cmdEmpty,
  output logic              lastSlot,
  output logic              memWrite,
  output logic              memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  input  logic [XLEN-1:0]   memRdata,
  output logic [4:0]        rfReadIdx,
  input  logic [XLEN-1:0]   rfReadData,
  output logic              rfWriteEn,
  output logic [4:0]        rfWriteIdx,
  output logic [XLEN-1:0]   rfWriteData
);

  localparam int COUNT_W     = 4;
  localparam int REG_W       = 5;
  localparam int TABLE_LEN   = BASE_RUN + 1;
  localparam int SLOT_W      = $clog2(TABLE_LEN + 2);
  localparam int WORD_W      = 32;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int DWORD_BYTES = XLEN / 8;

  // Register table: a contiguous run followed by one extra entry
  logic [REG_W-1:0] regTable [TABLE_LEN];
  for (genvar g = 0; g < TABLE_LEN; g++) begin : gTable
    localparam int ENTRY = (g < BASE_RUN) ? (BASE_FIRST + g) : EXTRA_REG;
    assign regTable[g] = REG_W'(ENTRY);
  end

  function automatic logic [SLOT_W-1:0] baseCount(input logic [4:0] lst);
    int n;
    n = int'(lst[COUNT_W-1:0]);
    if (n >= 1 && n <= TABLE_LEN) return SLOT_W'(n);
    return '0;
  endfunction

  logic [ADDR_W-1:0] addrQ;
  logic [SLOT_W-1:0] slotQ, baseQ, totalQ;
  logic              loadQ, doubleQ;
  logic [SLOT_W-1:0] newBase;
  logic [REG_W-1:0]  curReg;
  logic [ADDR_W-1:0] stride;
  logic [XLEN-1:0]   loadExt, storeExt;

  assign newBase  = baseCount(regList);
  assign cmdEmpty = (newBase == '0) && !regList[COUNT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      slotQ   <= '0;
      baseQ   <= '0;
      totalQ  <= '0;
      loadQ   <= 1'b0;
      doubleQ <= 1'b0;
    end else if (strobes.capture) begin
      addrQ   <= baseAddr;
      slotQ   <= '0;
      baseQ   <= newBase;
      totalQ  <= newBase + SLOT_W'(regList[COUNT_W]);
      loadQ   <= isLoad;
      doubleQ <= isDouble;
    end else if (strobes.step) begin
      addrQ   <= addrQ + stride;
      slotQ   <= slotQ + 1'b1;
    end
  end

  assign stride = doubleQ ? ADDR_W'(DWORD_BYTES) : ADDR_W'(WORD_BYTES);

  // Current register: table entry while within the base run, else link
  always_comb begin
    curReg = REG_W'(LINK_REG);
    if (slotQ < baseQ) begin
      for (int i = 0; i < TABLE_LEN; i++) begin
        if (SLOT_W'(i) == slotQ) curReg = regTable[i];
      end
    end
  end

  assign lastSlot = (SLOT_W'(slotQ + 1'b1) == totalQ);

  if (XLEN > WORD_W) begin : gWide
    assign loadExt  = doubleQ ? memRdata
                    : {{(XLEN-WORD_W){memRdata[WORD_W-1]}}, memRdata[WORD_W-1:0]};
    assign storeExt = doubleQ ? rfReadData
                    : {{(XLEN-WORD_W){1'b0}}, rfReadData[WORD_W-1:0]};
  end else begin : gNarrow
    assign loadExt  = memRdata;
    assign storeExt = rfReadData;
  end

  assign memAddr     = addrQ;
  assign memSize     = doubleQ;
  assign memWrite    = strobes.active & ~loadQ;
  assign memWdata    = (strobes.active & ~loadQ) ? storeExt : '0;
  assign rfReadIdx   = curReg;
  assign rfWriteIdx  = curReg;
  assign rfWriteData = loadExt;
  assign rfWriteEn   = strobes.step & loadQ;

endmodule

// File: rtl/lsm_sequencer.sv
`timescale 1ns/1ps
module lsm_sequencer
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [4:0]        regList,
  input  logic              isLoad,
  input  logic              isDouble,
  output logic              memReq,
  output logic              memWrite,
  output logic              memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  input  logic              memReady,
  input  logic [XLEN-1:0]   memRdata,
  output logic [4:0]        rfReadIdx,
  input  logic [XLEN-1:0]   rfReadData,
  output logic              rfWriteEn,
  output logic [4:0]        rfWriteIdx,
  output logic [XLEN-1:0]   rfWriteData,
  output logic              busy,
  output logic              done
);

  lsmStrobeT strobes;
  logic      cmdEmpty;
  logic      lastSlot;

  lsm_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmdEmpty (cmdEmpty),
    .lastSlot (lastSlot),
    .memReady (memReady),
    .strobes  (strobes),
    .memReq   (memReq),
    .busy     (busy),
    .done     (done)
  );

  lsm_datapath #(
    .ADDR_W (ADDR_W),
    .XLEN   (XLEN)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .baseAddr    (baseAddr),
    .regList     (regList),
    .isLoad      (isLoad),
    .isDouble    (isDouble),
    .cmdEmpty    (cmdEmpty),
    .lastSlot    (lastSlot),
    .memWrite    (memWrite),
    .memSize     (memSize),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .rfReadIdx   (rfReadIdx),
    .rfReadData  (rfReadData),
    .rfWriteEn   (rfWriteEn),
    .rfWriteIdx  (rfWriteIdx),
    .rfWriteData (rfWriteData)
  );

endmodule

// File: rtl/lsm_checker.sv
`timescale 1ns/1ps
module lsm_checker #(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWrite,
  input logic              memSize,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady,
  input logic [4:0]        rfReadIdx,
  input logic              rfWriteEn,
  input logic              busy,
  input logic              done
);

  localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DWORD_STEP = ADDR_W'(XLEN / 8);
  localparam logic [4:0]        LINK_IDX   = 5'd31;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !rfWriteEn && !done)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(rfReadIdx))); // R8

  AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) ##1 memReq |->
      memAddr == $past(memAddr) + (memSize ? DWORD_STEP : WORD_STEP)); // R5

  AST_LINK_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && rfReadIdx == LINK_IDX) |=> !memReq); // R4

  AST_WRITE_ON_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    rfWriteEn |-> (memReq && memReady && !memWrite)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R9

endmodule

bind lsm_sequencer lsm_checker #(
  .ADDR_W (ADDR_W),
  .XLEN   (XLEN)
) i_lsmChecker (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memWrite  (memWrite),
  .memSize   (memSize),
  .memAddr   (memAddr),
  .memReady  (memReady),
  .rfReadIdx (rfReadIdx),
  .rfWriteEn (rfWriteEn),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_lsm_sequencer.sv
`timescale 1ns/1ps
module test_lsm_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int XLEN   = 64;
  localparam int OP_LIMIT = 200;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [4:0]        regList = '0;
  logic              isLoad = 1'b0;
  logic              isDouble = 1'b0;
  logic              memReq, memWrite, memSize;
  logic [ADDR_W-1:0] memAddr;
  logic [XLEN-1:0]   memWdata;
  logic              memReady = 1'b0;
  logic [XLEN-1:0]   memRdata;
  logic [4:0]        rfReadIdx;
  logic [XLEN-1:0]   rfReadData;
  logic              rfWriteEn;
  logic [4:0]        rfWriteIdx;
  logic [XLEN-1:0]   rfWriteData;
  logic              busy, done;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsm_sequencer #(.ADDR_W(ADDR_W), .XLEN(XLEN)) i_lsm_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .regList(regList), .isLoad(isLoad), .isDouble(isDouble),
    .memReq(memReq), .memWrite(memWrite), .memSize(memSize),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata), .rfReadIdx(rfReadIdx), .rfReadData(rfReadData),
    .rfWriteEn(rfWriteEn), .rfWriteIdx(rfWriteIdx), .rfWriteData(rfWriteData),
    .busy(busy), .done(done)
  );

  // Models: register file contents and memory contents as functions
  function automatic logic [XLEN-1:0] rfInit(input logic [4:0] idx);
    return {(32'(idx) * 32'h1111_1111) ^ 32'hC0DE_0000,
            (32'(idx) * 32'h0101_0101) ^ 32'h8000_0000};
  endfunction

  function automatic logic [XLEN-1:0] memFn(input logic [ADDR_W-1:0] a);
    return {a ^ 32'h5A5A_5A5A, ~a};
  endfunction

  assign rfReadData = rfInit(rfReadIdx);
  assign memRdata   = memFn(memAddr);

  function automatic int baseOf(input logic [4:0] lst);
    int n;
    n = int'(lst[3:0]);
    return (n >= 1 && n <= 9) ? n : 0;
  endfunction

  function automatic logic [4:0] expReg(input logic [4:0] lst, input int k);
    if (k < baseOf(lst)) return (k < 8) ? 5'(16 + k) : 5'd30;
    return 5'd31;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [4:0]  list;
    logic        ld;
    logic        dbl;
    logic [31:0] base;
    logic [7:0]  ready;
    logic [3:0]  beats;
  } vecT;

  localparam int NVEC = 11;
  localparam vecT VECS [NVEC] = '{
    '{5'b00011, 1'b0, 1'b0, 32'h0000_1000, 8'hFF,       4'd3},
    '{5'b10101, 1'b1, 1'b0, 32'h0000_2000, 8'b10110101, 4'd6},
    '{5'b01001, 1'b0, 1'b1, 32'h0000_3000, 8'hFF,       4'd9},
    '{5'b11001, 1'b1, 1'b1, 32'h8000_0000, 8'b11001100, 4'd10},
    '{5'b11010, 1'b0, 1'b0, 32'h0000_4000, 8'hFF,       4'd1},
    '{5'b11111, 1'b1, 1'b0, 32'h7FFF_FFF0, 8'b00010001, 4'd1},
    '{5'b00001, 1'b1, 1'b1, 32'h0000_0010, 8'b01010101, 4'd1},
    '{5'b10000, 1'b0, 1'b1, 32'h0000_0500, 8'hFF,       4'd1},
    '{5'b01000, 1'b1, 1'b0, 32'h8000_0100, 8'b11101110, 4'd8},
    '{5'b00000, 1'b1, 1'b0, 32'h0000_0600, 8'hFF,       4'd0},
    '{5'b01111, 1'b0, 1'b1, 32'h0000_0700, 8'hFF,       4'd0}
  };

  // Runs one command; noise = issue a second start while busy
  task automatic runOp(input vecT v, input bit noise);
    int k = 0;
    int lastAcc = -1;
    int total;
    bit stalled = 1'b0;
    bit finished = 1'b0;
    logic [ADDR_W-1:0] holdAddr = '0;
    logic [4:0] holdIdx = '0;
    logic [ADDR_W-1:0] expA;
    logic [4:0] expR;
    logic [XLEN-1:0] expD;
    string rtag;
    total = baseOf(v.list) + int'(v.list[4]);
    chk(total == int'(v.beats), "R2", "model beat count", 64'(total), 64'(v.beats));
    @(negedge clk);
    start = 1'b1; baseAddr = v.base; regList = v.list;
    isLoad = v.ld; isDouble = v.dbl; memReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < OP_LIMIT; c++) begin
      memReady = v.ready[c % 8];
      if (noise && c == 1) begin
        start = 1'b1; regList = 5'b11111; baseAddr = 32'hDEAD_0000; isLoad = ~v.ld;
      end else begin
        start = 1'b0;
      end
      #1;
      if (done) begin
        rtag = (total == 0) ? "R10" : "R9";
        chk(k == total, rtag, "beats before done", 64'(k), 64'(total));
        chk(lastAcc == c - 1 || (total == 0 && c == 0), rtag, "done timing",
            64'(c), 64'(lastAcc + 1));
        chk(busy == 1'b1, "R9", "busy during done", 64'(busy), 64'd1);
        finished = 1'b1;
        break;
      end
      if (memReq) begin
        if (noise) chk(busy && k < total, "R11", "beat within original run",
                       64'(k), 64'(total));
        if (stalled) begin
          chk(memAddr == holdAddr && rfReadIdx == holdIdx, "R8", "stall hold",
              {27'b0, rfReadIdx, memAddr}, {27'b0, holdIdx, holdAddr});
        end
        if (k >= total) begin
          chk(1'b0, (v.list[3:0] == 0 || v.list[3:0] > 9) ? "R3" : "R2",
              "extra beat", 64'(k), 64'(total));
        end else if (memReady) begin
          expR = expReg(v.list, k);
          expA = v.base + ADDR_W'(k * (v.dbl ? 8 : 4));
          rtag = (expR == 5'd31) ? "R4" : "R2";
          chk(rfReadIdx == expR, rtag, "register index", 64'(rfReadIdx), 64'(expR));
          chk(memAddr == expA, (expR == 5'd31) ? "R4" : "R5", "address",
              64'(memAddr), 64'(expA));
          chk(memWrite == ~v.ld && memSize == v.dbl, "R5", "write/size",
              {62'b0, memWrite, memSize}, {62'b0, ~v.ld, v.dbl});
          if (v.ld) begin
            expD = v.dbl ? memFn(expA) : {{32{memFn(expA)[31]}}, memFn(expA)[31:0]};
            chk(rfWriteEn && rfWriteIdx == expR, "R6", "write enable/index",
                {58'b0, rfWriteEn, rfWriteIdx}, {58'b0, 1'b1, expR});
            chk(rfWriteData == expD, "R6", "load data", rfWriteData, expD);
          end else begin
            expD = v.dbl ? rfInit(expR) : {32'b0, rfInit(expR)[31:0]};
            chk(memWdata == expD && !rfWriteEn, "R7", "store data", memWdata, expD);
          end
          k++;
          lastAcc = c;
          stalled = 1'b0;
        end else begin
          chk(!rfWriteEn, "R8", "no write while stalled", 64'(rfWriteEn), 64'd0);
          stalled = 1'b1;
          holdAddr = memAddr;
          holdIdx = rfReadIdx;
        end
      end else begin
        chk(1'b0, "R9", "request missing while running", 64'(k), 64'(total));
      end
      @(negedge clk);
    end
    if (!finished) chk(1'b0, "R9", "operation never completed", 64'(k), 64'(total));
    @(negedge clk);
    start = 1'b0; memReady = 1'b0;
    #1;
    chk(!busy && !done && !memReq, "R9", "idle after done",
        {61'b0, busy, done, memReq}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL R9 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !memReq && !rfWriteEn && !done, "R1", "state in reset",
        {60'b0, busy, memReq, rfWriteEn, done}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!busy && !memReq && !rfWriteEn && !done, "R1", "state after reset",
        {60'b0, busy, memReq, rfWriteEn, done}, 64'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++) runOp(VECS[i], 1'b0);

    // R11: second start while busy has no effect
    runOp('{5'b10100, 1'b0, 1'b0, 32'h0000_0A00, 8'b11011011, 4'd5}, 1'b1);
    runOp('{5'b00010, 1'b1, 1'b1, 32'h0000_0B00, 8'b10000001, 4'd2}, 1'b1);

    // R8: long stall on a store, then resume
    runOp('{5'b10010, 1'b0, 1'b1, 32'hFFFF_FFE8, 8'b10000000, 4'd3}, 1'b0);

    // R1: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; regList = 5'b11001; baseAddr = 32'h0000_0C00;
    isLoad = 1'b1; isDouble = 1'b0; memReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(busy && memReq, "R1", "running before mid reset",
        {62'b0, busy, memReq}, 64'd3);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(!busy && !memReq && !rfWriteEn && !done, "R1", "idle after mid reset",
        {60'b0, busy, memReq, rfWriteEn, done}, 64'd0);

    // Operation after the mid reset starts cleanly
    runOp('{5'b10001, 1'b1, 1'b0, 32'h0000_0D00, 8'hFF, 4'd2}, 1'b0);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule